// File: doc/BRIEF.md
# Dual-Thread Tagged Instruction Line Cache

This block is a small direct-mapped store of instruction lines that two hardware threads share. Each thread keeps its own fetch pointer, which holds a line address. Each clock an arbiter picks at most one thread. That thread's pointer indexes the array with its low bits, and the result shows up in the same cycle as a per-thread hit or miss pulse. On a hit the line data is driven out.

Every entry records the identifier of the thread that filled it. A line filled by one thread therefore never satisfies a lookup from the other thread, even when the address is the same. The array is not divided between the threads, so either thread may own any number of entries.

On a miss the block asks the next memory level for the line at the pointer, tagged with the thread. The thread then stays out of arbitration until the matching response has been written. A redirect loads a new pointer and abandons any outstanding miss of that thread.

Top module: `tt_icache`

## Requirements
- R1: A thread's pointer moves to the next line address (plus one) only in a cycle where that thread hits; with no hit and no redirect it keeps its value.
- R2: At most one thread is looked up per cycle; that thread shows exactly one of hit or miss, and the other thread shows neither.
- R3: When both threads are eligible, the thread not picked at the last lookup is picked. Directly after reset, thread 0 has priority.
- R4: A thread that is stalled, has a miss outstanding, or is being redirected is not eligible; whenever at least one thread is eligible, a lookup takes place, so a single eligible thread is served in every cycle.
- R5: A hit requires a valid entry at index = pointer bits [3:0], a stored upper address (pointer bits [15:4]) equal to the pointer's, and a stored thread identifier equal to the looking-up thread.
- R6: In a miss cycle, and only then, fill_req_o is high with fill_tid_o set to the missing thread and fill_addr_o set to its pointer; on a hit fill_req_o stays low.
- R7: After a miss, the thread makes no lookups until a response with fill_vld_i high and fill_tid_i equal to that thread arrives. The response writes the line at the thread's pointer, and the following lookup of that address hits and drives the returned data on line_o.
- R8: A redirect loads the thread's pointer at the next edge and cancels its outstanding miss; a response for that thread arriving with no miss outstanding writes nothing.
- R9: The array is shared without partitioning: one thread can fill all 16 entries and then hit on each of them.
- R10: Reset clears every valid bit and both pointers to zero, so the first lookup of a thread after reset misses at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 2 | Per-thread stall; bit t holds thread t out of arbitration |
| redir_vld_i | input | 2 | Per-thread pointer load request |
| redir_addr_i | input | 2x16 | Per-thread line address to load |
| hit_o | output | 2 | Per-thread hit pulse for this cycle's lookup |
| miss_o | output | 2 | Per-thread miss pulse for this cycle's lookup |
| line_o | output | 32 | Line data; valid when a bit of hit_o is high |
| fill_req_o | output | 1 | Line request to the next level |
| fill_tid_o | output | 1 | Thread of the request |
| fill_addr_o | output | 16 | Line address of the request |
| fill_vld_i | input | 1 | Returned line is present |
| fill_tid_i | input | 1 | Thread the returned line belongs to |
| fill_line_i | input | 32 | Returned line data |

## Verification
Checked on every cycle by the assertions: the grant is one-hot or idle and goes only to an eligible thread, the alternation rule, the absence of idle slots while a thread is eligible, pointer stepping and holding, the blocking effect of stalls and outstanding misses, and a request being followed by an outstanding miss. The bench scenarios cover behaviour that depends on the stored contents. Those are the thread-ID mismatch that turns a same-address lookup into a miss, a cancelled miss whose late response must leave the array untouched, the correct data returned after a fill, and one thread occupying all sixteen entries.

// File: rtl/tt_icache_pkg.sv
package tt_icache_pkg;
  localparam int unsigned NUM_THR = 2;
  typedef logic tid_t;
endpackage

// File: rtl/tt_arb.sv
module tt_arb
  import tt_icache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] elig_i,
  output logic [NUM_THR-1:0] gnt_o
);
  tid_t last_q, last_d;

  always_comb begin
    gnt_o = '0;
    if (elig_i == 2'b11) begin
      gnt_o = last_q ? 2'b01 : 2'b10;
    end else begin
      gnt_o = elig_i;
    end
    last_d = (|gnt_o) ? gnt_o[1] : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_d;
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  p_grant_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~elig_i) == 2'b00);
  p_no_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_i) |-> (|gnt_o));
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i == 2'b11) |-> !gnt_o[last_q]);
endmodule

// File: rtl/tt_thread_ptr.sv
module tt_thread_ptr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              adv_i,
  input  logic              miss_i,
  input  logic              fill_done_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pend_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pend_q, pend_d;

  always_comb begin
    pc_d   = pc_q;
    pend_d = pend_q;
    if (ld_i) begin
      pc_d   = ld_addr_i;
      pend_d = 1'b0;
    end else begin
      if (adv_i)       pc_d   = pc_q + ADDR_W'(1);
      if (miss_i)      pend_d = 1'b1;
      else if (fill_done_i) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pend_q <= pend_d;
    end
  end

  assign pc_o   = pc_q;
  assign pend_o = pend_q;

  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_i) |=> $stable(pc_q));
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && adv_i) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));
  p_redirect_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (!pend_q && pc_q == $past(ld_addr_i)));
endmodule

// File: rtl/tt_line_store.sv
module tt_line_store
  import tt_icache_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  tid_t              rd_tid_i,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  tid_t              wr_tid_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  tid_t               own_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  always_comb begin
    rd_hit_o  = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i)
                && (own_q[rd_idx_i] == rd_tid_i);
    rd_data_o = data_q[rd_idx_i];
    vld_d     = vld_q;
    if (wr_en_i) vld_d[wr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic wr_sel;
    assign wr_sel = wr_en_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (wr_sel) begin
        tag_q[e]  <= wr_tag_i;
        own_q[e]  <= wr_tid_i;
        data_q[e] <= wr_data_i;
      end
    end
  end

  p_write_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> vld_q[$past(wr_idx_i)]);
endmodule

// File: rtl/tt_icache.sv
module tt_icache
  import tt_icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   stall_i,
  input  logic [1:0]                   redir_vld_i,
  input  logic [1:0][ADDR_W-1:0]       redir_addr_i,
  output logic [1:0]                   hit_o,
  output logic [1:0]                   miss_o,
  output logic [DATA_W-1:0]            line_o,
  output logic                         fill_req_o,
  output logic                         fill_tid_o,
  output logic [ADDR_W-1:0]            fill_addr_o,
  input  logic                         fill_vld_i,
  input  logic                         fill_tid_i,
  input  logic [DATA_W-1:0]            fill_line_i
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0]  pc [NUM_THR];
  logic [NUM_THR-1:0] pend, elig, gnt, fill_done;
  tid_t               sel_tid;
  logic [ADDR_W-1:0]  sel_pc, wr_pc;
  logic               rd_hit, wr_ok;
  logic [DATA_W-1:0]  rd_data;

  always_comb begin
    elig    = ~stall_i & ~pend & ~redir_vld_i;
    sel_tid = gnt[1];
    sel_pc  = pc[sel_tid];
    hit_o   = gnt & {NUM_THR{rd_hit}};
    miss_o  = gnt & {NUM_THR{~rd_hit}};
    wr_ok   = fill_vld_i && pend[fill_tid_i] && !redir_vld_i[fill_tid_i];
    wr_pc   = pc[fill_tid_i];
  end

  assign line_o      = rd_data;
  assign fill_req_o  = |miss_o;
  assign fill_tid_o  = sel_tid;
  assign fill_addr_o = sel_pc;

  tt_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (elig),
    .gnt_o  (gnt)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign fill_done[t] = wr_ok && (fill_tid_i == tid_t'(t));
    tt_thread_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_i        (redir_vld_i[t]),
      .ld_addr_i   (redir_addr_i[t]),
      .adv_i       (hit_o[t]),
      .miss_i      (miss_o[t]),
      .fill_done_i (fill_done[t]),
      .pc_o        (pc[t]),
      .pend_o      (pend[t])
    );
  end

  tt_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_i  (sel_pc[IDX_W-1:0]),
    .rd_tag_i  (sel_pc[ADDR_W-1:IDX_W]),
    .rd_tid_i  (sel_tid),
    .rd_hit_o  (rd_hit),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_ok),
    .wr_idx_i  (wr_pc[IDX_W-1:0]),
    .wr_tag_i  (wr_pc[ADDR_W-1:IDX_W]),
    .wr_tid_i  (fill_tid_i),
    .wr_data_i (fill_line_i)
  );

  p_single_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit_o | miss_o) <= 1) && ((hit_o & miss_o) == 2'b00));
  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i & (hit_o | miss_o)) == 2'b00);
  p_pend_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & (hit_o | miss_o)) == 2'b00);
  p_req_opens_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_o |=> pend[$past(fill_tid_o)]);
endmodule

// File: tb/tt_icache_bench.sv
module tt_icache_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        stall, rv;
  logic [1:0][15:0]  ra;
  logic [1:0]        hit, miss;
  logic [31:0]       line;
  logic              freq, ftid_o;
  logic [15:0]       faddr;
  logic              fv, ft;
  logic [31:0]       fd;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  logic [15:0] req_addr [2];

  always #2 clk = ~clk;

  tt_icache u_tt_icache (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .redir_vld_i(rv),
    .redir_addr_i(ra), .hit_o(hit), .miss_o(miss), .line_o(line),
    .fill_req_o(freq), .fill_tid_o(ftid_o), .fill_addr_o(faddr),
    .fill_vld_i(fv), .fill_tid_i(ft), .fill_line_i(fd)
  );

  function automatic logic [31:0] mk(input logic t, input logic [15:0] a);
    return {8'h5A, 7'h00, t, a};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 5000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp<=5000 cycles", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, sample 1 ns later
  task automatic cyc(input logic [1:0] s, input logic [1:0] r,
                     input logic [15:0] a0, input logic [15:0] a1,
                     input logic f, input logic t);
    @(negedge clk);
    stall = s; rv = r; ra[0] = a0; ra[1] = a1; fv = f; ft = t;
    fd = mk(t, req_addr[t]);
    #1;
    if (freq) req_addr[ftid_o] = faddr;
  endtask

  task automatic fill_line(input logic t, input logic [15:0] a);
    logic [1:0] s, r;
    s = t ? 2'b01 : 2'b10;
    r = t ? 2'b10 : 2'b01;
    cyc(s, r, a, a, 1'b0, 1'b0);
    cyc(s, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R6 setup miss", {miss, freq, ftid_o, faddr}, {(t ? 2'b10 : 2'b01), 1'b1, t, a});
    cyc(s, 2'b00, 0, 0, 1'b1, t);
    cyc(s, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R7 setup hit", {hit, line}, {(t ? 2'b10 : 2'b01), mk(t, a)});
  endtask

  task automatic t_reset_and_fill();
    cyc(2'b11, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R10 idle after reset", {hit, miss, freq}, 5'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R10 first lookup misses at 0", {miss, hit, freq, ftid_o, faddr}, {2'b01, 2'b00, 1'b1, 1'b0, 16'h0000});
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R7 no lookup while pending", {hit, miss, freq}, 5'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b1, 1'b0);
    chk("R7 no lookup in response cycle", {hit, miss}, 4'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R7 hit after fill with data", {hit, miss, line}, {2'b01, 2'b00, mk(1'b0, 16'h0000)});
    chk("R6 no request on hit", freq, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R1 pointer advanced by one", {miss, faddr}, {2'b01, 16'h0001});
    cyc(2'b10, 2'b00, 0, 0, 1'b1, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R1 pointer held during miss", {hit, line}, {2'b01, mk(1'b0, 16'h0001)});
  endtask

  task automatic t_thread_tag();
    fill_line(1'b0, 16'h0040);
    cyc(2'b01, 2'b10, 0, 16'h0040, 1'b0, 1'b0);
    cyc(2'b01, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R5 same address other thread misses", {hit, miss, ftid_o, faddr}, {2'b00, 2'b10, 1'b1, 16'h0040});
    cyc(2'b01, 2'b00, 0, 0, 1'b1, 1'b1);
    cyc(2'b01, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R5 thread 1 hits own line", {hit, line}, {2'b10, mk(1'b1, 16'h0040)});
  endtask

  task automatic t_alternate();
    fill_line(1'b0, 16'h0100);
    fill_line(1'b0, 16'h0101);
    fill_line(1'b1, 16'h0208);
    fill_line(1'b1, 16'h0209);
    cyc(2'b00, 2'b11, 16'h0100, 16'h0208, 1'b0, 1'b0);
    chk("R4 redirecting threads not looked up", {hit, miss}, 4'b0);
    cyc(2'b00, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R3 thread 0 after thread 1", {hit, miss, line}, {2'b01, 2'b00, mk(1'b0, 16'h0100)});
    cyc(2'b00, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R3 thread 1 next", {hit, miss, line}, {2'b10, 2'b00, mk(1'b1, 16'h0208)});
    cyc(2'b00, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R3 thread 0 again", {hit, miss, line}, {2'b01, 2'b00, mk(1'b0, 16'h0101)});
    cyc(2'b00, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R2 one thread per cycle", {hit, miss, line}, {2'b10, 2'b00, mk(1'b1, 16'h0209)});
  endtask

  task automatic t_stall_other();
    cyc(2'b00, 2'b11, 16'h0100, 16'h0208, 1'b0, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R4 sole eligible thread slot 1", {hit, line}, {2'b01, mk(1'b0, 16'h0100)});
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R4 sole eligible thread slot 2", {hit, line}, {2'b01, mk(1'b0, 16'h0101)});
  endtask

  task automatic t_redirect_cancel();
    cyc(2'b10, 2'b01, 16'h0300, 0, 1'b0, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R8 loaded pointer used", {miss, faddr}, {2'b01, 16'h0300});
    cyc(2'b10, 2'b01, 16'h0300, 0, 1'b0, 1'b0);
    cyc(2'b11, 2'b00, 0, 0, 1'b1, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R8 late response not written", {hit, miss, freq}, {2'b00, 2'b01, 1'b1});
    cyc(2'b10, 2'b00, 0, 0, 1'b1, 1'b0);
    cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R8 new miss served", {hit, line}, {2'b01, mk(1'b0, 16'h0300)});
  endtask

  task automatic t_unpartitioned();
    int good = 0;
    for (int i = 0; i < 16; i++) fill_line(1'b0, 16'h0400 + 16'(i));
    cyc(2'b10, 2'b01, 16'h0400, 0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      cyc(2'b10, 2'b00, 0, 0, 1'b0, 1'b0);
      if (hit == 2'b01 && line == mk(1'b0, 16'h0400 + 16'(i))) good++;
    end
    chk("R9 one thread holds all 16 entries", good, 16);
    cyc(2'b01, 2'b10, 0, 16'h0405, 1'b0, 1'b0);
    cyc(2'b01, 2'b00, 0, 0, 1'b0, 1'b0);
    chk("R5 thread 1 misses thread 0 line", {hit, miss}, {2'b00, 2'b10});
  endtask

  initial begin
    rst_n = 1'b0; stall = 2'b11; rv = '0; ra = '0; fv = 1'b0; ft = 1'b0; fd = '0;
    req_addr[0] = '0; req_addr[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_fill();
    t_thread_tag();
    t_alternate();
    t_stall_other();
    t_redirect_cancel();
    t_unpartitioned();
    summary();
    $finish;
  end
endmodule